// File: doc/BRIEF.md
# Phase Code Output Sequencer

This block takes the 6-bit phase codes of thirty-two antenna elements, arranged as two groups of sixteen, and delivers them over one narrow shared output: a 6-bit data bus with a 5-bit element address beside it. This replaces 192 dedicated output pins. A single 5-bit sweep counter does two jobs. It selects one input lane of a 32-to-1 multiplexer, and it addresses a 32-word by 6-bit store. During a store sweep, the selected lane is written at the counter value. During a delivery sweep, the stored words come out one per clock, each with its address and a valid strobe.

The sequencer waits idle until a new steering gradient is announced. The gradient strobe starts a store sweep at element 0. After element 31 has been stored, the block switches its read/write bit to read. It then replays the store continuously, wrapping from element 31 back to 0, until the next gradient arrives. A gradient that arrives at any point restarts the store sweep from element 0. The logic that computes the phase codes lies outside this block.

Top module: `phs_seq_top`

## Requirements
- R1: While reset is low at a clock edge, and after that edge, `dvalid`, `dout`, `aout` and `sweep_rd` are all 0.
- R2: After reset and before the first `grad_valid`, the block stays idle whatever is on `codes_in`: `dvalid` and `sweep_rd` remain 0.
- R3: A `grad_valid` sampled high at edge E0 starts a store sweep. `sweep_rd` is 0 (write) after edges E0 through E31 and becomes 1 (read) after edge E32.
- R4: Element j's code is taken from `codes_in[6*j+5 : 6*j]` at edge E(j+1) of the store sweep. Reading address j returns exactly that code.
- R5: The first delivered word appears after edge E33 with `aout` = 0. Each word's address is aligned with its data, one clock after the internal read.
- R6: During delivery, `dvalid` is 1 on every cycle and `aout` steps by one each cycle, wrapping from 31 to 0. The stored set repeats without gaps until a new gradient arrives.
- R7: A `grad_valid` sampled during a store or a delivery sweep makes `dvalid` and `sweep_rd` 0 after that edge. It restarts the store from element 0, so the next delivery carries only the codes present during the restarted sweep.
- R8: Whenever `dvalid` is 0, `dout` and `aout` are 0.
- R9: Changes on `codes_in` after the store sweep has finished have no effect on the delivered words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| grad_valid | input | 1 | One-cycle strobe: a new steering gradient has arrived |
| codes_in | input | 192 | Thirty-two 6-bit phase codes, element j in bits 6j+5..6j |
| sweep_rd | output | 1 | Read/write bit: 0 = store sweep or idle, 1 = delivery sweep |
| dvalid | output | 1 | Delivered word valid |
| dout | output | 6 | Delivered phase code |
| aout | output | 5 | Element address of the delivered code |

## Verification
A counter that skips or repeats a value shows up on `aout` in the first delivered cycle after the fault, as a break in the one-per-clock step or as a wrap that is not 31 to 0. A wrong multiplexer lane or a wrong write address does not show at once. It appears one full sweep later, when the word delivered at some address differs from the code that was driven for that element. A read/write bit stuck in one state, or a restart that fails to clear it, is visible within 33 clocks of a gradient, because valid data either arrives early or never arrives.

// File: rtl/phs_pkg.sv
// Package: shared types of the phase code output sequencer.
// Assumes: none; holds only the sweep state encoding.
package phs_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_STORE = 2'd1,
        SQ_SHOW  = 2'd2
    } sweep_state_t;

endpackage

// File: rtl/phs_ctrl.sv
// Sweep controller: owns the shared counter and the read/write bit.
// Assumes: grad_valid is a single-cycle strobe; N_ELEM >= 2.
// A gradient always wins and restarts the store sweep at element 0.
module phs_ctrl
    import phs_pkg::*;
#(
    parameter int N_ELEM = 32,
    localparam int ADDR_W = $clog2(N_ELEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              grad_valid,
    output logic [ADDR_W-1:0] cnt,
    output logic              wr_en,
    output logic              rd_en,
    output logic              rw_bit
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_ELEM - 1);

    sweep_state_t state;

    // Sweep state and counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SQ_IDLE;
            cnt   <= '0;
        end else if (grad_valid) begin
            state <= SQ_STORE;
            cnt   <= '0;
        end else begin
            case (state)
                SQ_STORE: begin
                    if (cnt == LAST) begin
                        state <= SQ_SHOW;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_SHOW: begin
                    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
                end
                default: begin
                    cnt <= cnt;
                end
            endcase
        end
    end

    // Strobes derived from the state; a gradient suppresses both.
    always_comb begin
        wr_en  = (state == SQ_STORE) && !grad_valid;
        rd_en  = (state == SQ_SHOW)  && !grad_valid;
        rw_bit = (state == SQ_SHOW);
    end

endmodule

// File: rtl/phs_mux.sv
// N-to-1 code selector: picks lane `sel` of a flat code bus.
// Assumes: lane j occupies bits CODE_W*j+CODE_W-1 .. CODE_W*j.
module phs_mux #(
    parameter int N_ELEM = 32,
    parameter int CODE_W = 6,
    localparam int ADDR_W = $clog2(N_ELEM)
) (
    input  logic [N_ELEM*CODE_W-1:0] codes,
    input  logic [ADDR_W-1:0]        sel,
    output logic [CODE_W-1:0]        y
);

    logic [CODE_W-1:0] lanes [N_ELEM];

    for (genvar g = 0; g < N_ELEM; g++) begin : g_lane
        assign lanes[g] = codes[g*CODE_W +: CODE_W];
    end

    // Lane selection; out-of-range selects give zero.
    always_comb begin
        if (int'(sel) < N_ELEM) y = lanes[sel];
        else                    y = '0;
    end

endmodule

// File: rtl/phs_mem.sv
// Code store: N_ELEM words of CODE_W bits, one write port, one read port.
// Assumes: read data is registered (one clock latency); contents are not reset.
module phs_mem #(
    parameter int N_ELEM = 32,
    parameter int CODE_W = 6,
    localparam int ADDR_W = $clog2(N_ELEM)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [CODE_W-1:0] wdata,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [CODE_W-1:0] rdata
);

    logic [CODE_W-1:0] words [N_ELEM];

    // Array write.
    always_ff @(posedge clk) begin
        if (we) words[waddr] <= wdata;
    end

    // Registered read.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= words[raddr];
    end

endmodule

// File: rtl/phs_seq_top.sv
// Phase code output sequencer top: a counter-driven selector feeds the store,
// and the store is replayed onto a narrow data/address bus.
// Assumes: codes_in is stable during the store sweep; synchronous active-low reset.
module phs_seq_top #(
    parameter int N_ELEM = 32,
    parameter int CODE_W = 6,
    localparam int ADDR_W = $clog2(N_ELEM)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     grad_valid,
    input  logic [N_ELEM*CODE_W-1:0] codes_in,
    output logic                     sweep_rd,
    output logic                     dvalid,
    output logic [CODE_W-1:0]        dout,
    output logic [ADDR_W-1:0]        aout
);

    logic [ADDR_W-1:0] cnt;
    logic              wr_en;
    logic              rd_en;
    logic [CODE_W-1:0] sel_code;
    logic [CODE_W-1:0] rd_word;
    logic [ADDR_W-1:0] addr_q;

    phs_ctrl #(.N_ELEM(N_ELEM)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .grad_valid (grad_valid),
        .cnt        (cnt),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .rw_bit     (sweep_rd)
    );

    phs_mux #(.N_ELEM(N_ELEM), .CODE_W(CODE_W)) u_mux (
        .codes (codes_in),
        .sel   (cnt),
        .y     (sel_code)
    );

    phs_mem #(.N_ELEM(N_ELEM), .CODE_W(CODE_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (cnt),
        .wdata (sel_code),
        .re    (rd_en),
        .raddr (cnt),
        .rdata (rd_word)
    );

    // Delay the address and valid by one clock to match the read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvalid <= 1'b0;
            addr_q <= '0;
        end else begin
            dvalid <= rd_en;
            addr_q <= rd_en ? cnt : '0;
        end
    end

    // Output gating: bus reads zero when no word is valid.
    always_comb begin
        dout = dvalid ? rd_word : '0;
        aout = dvalid ? addr_q  : '0;
    end

endmodule

// File: rtl/phs_seq_chk.sv
// Checker for the sequencer's port behaviour, bound into phs_seq_top.
// Assumes: synchronous active-low reset; checks begin one clock after reset.
module phs_seq_chk #(
    parameter int N_ELEM = 32,
    parameter int CODE_W = 6,
    localparam int ADDR_W = $clog2(N_ELEM)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              grad_valid,
    input logic              sweep_rd,
    input logic              dvalid,
    input logic [CODE_W-1:0] dout,
    input logic [ADDR_W-1:0] aout
);

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(N_ELEM - 1);

    logic past_ok;

    // Marks that one clock under reset has passed.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b1;
    end

    AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n || past_ok !== 1'b1)
        !dvalid |-> (dout == '0 && aout == '0)); // R8

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n || past_ok !== 1'b1)
        (dvalid && $past(dvalid)) |->
            aout == (($past(aout) == LAST) ? '0 : $past(aout) + 1'b1)); // R6

    AST_GRAD_RESTART: assert property (@(posedge clk) disable iff (!rst_n || past_ok !== 1'b1)
        grad_valid |=> (!dvalid && !sweep_rd)); // R7

    AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n || past_ok !== 1'b1)
        $rose(dvalid) |-> aout == '0); // R5

    AST_VALID_IN_READ: assert property (@(posedge clk) disable iff (!rst_n || past_ok !== 1'b1)
        dvalid |-> sweep_rd); // R3

endmodule

bind phs_seq_top phs_seq_chk #(.N_ELEM(N_ELEM), .CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .grad_valid (grad_valid),
    .sweep_rd   (sweep_rd),
    .dvalid     (dvalid),
    .dout       (dout),
    .aout       (aout)
);

// File: tb/tb_phs_seq_top.sv
module tb_phs_seq_top;

    localparam int N = 32;
    localparam int W = 6;
    localparam int NV = 6;
    // Vector table: code pattern (mul, add), probe element, expected code there.
    localparam int VMUL [NV] = '{1, 3, 7, 0, 13, 63};
    localparam int VADD [NV] = '{0, 5, 63, 42, 1, 17};
    localparam int VPRB [NV] = '{31, 20, 9, 17, 5, 1};
    localparam int VEXP [NV] = '{31, 1, 62, 42, 2, 16};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         grad_valid = 1'b0;
    logic [N*W-1:0] codes_in = '0;
    logic         sweep_rd;
    logic         dvalid;
    logic [W-1:0] dout;
    logic [4:0]   aout;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    phs_seq_top dut (
        .clk(clk), .rst_n(rst_n), .grad_valid(grad_valid), .codes_in(codes_in),
        .sweep_rd(sweep_rd), .dvalid(dvalid), .dout(dout), .aout(aout)
    );

    function automatic int code_of(int mul, int add, int j);
        return (j * mul + add) % 64;
    endfunction

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic load(int mul, int add);
        for (int j = 0; j < N; j++) codes_in[j*W +: W] = W'(code_of(mul, add, j));
    endtask

    // Pulse gradient, walk the store sweep, stop at the negedge after E33.
    task automatic launch();
        @(negedge clk); grad_valid = 1'b1;
        @(negedge clk); grad_valid = 1'b0;
        for (int i = 0; i < 32; i++) begin
            chk("R3 store rw", sweep_rd, 0);
            chk("R8 idle dvalid", dvalid, 0);
            @(negedge clk);
        end
        chk("R3 read rw", sweep_rd, 1);
        chk("R5 no early data", dvalid, 0);
        @(negedge clk);
    endtask

    // Check n delivered words, starting at address 0.
    task automatic read_words(int mul, int add, int n);
        for (int k = 0; k < n; k++) begin
            chk("R6 dvalid", dvalid, 1);
            chk("R5 R6 aout", aout, k % N);
            chk("R4 dout", dout, code_of(mul, add, k % N));
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 dvalid", dvalid, 0);
        chk("R1 dout", dout, 0);
        chk("R1 aout", aout, 0);
        chk("R1 rw", sweep_rd, 0);
        rst_n = 1'b1;
        // R2: idle with codes present
        load(5, 9);
        repeat (40) begin
            @(negedge clk);
            chk("R2 idle dvalid", dvalid, 0);
            chk("R2 idle rw", sweep_rd, 0);
        end

        // Table walk
        for (int v = 0; v < NV; v++) begin
            load(VMUL[v], VADD[v]);
            launch();
            for (int k = 0; k < 40; k++) begin
                if (k % N == VPRB[v]) chk("R4 probe", dout, VEXP[v]);
                chk("R6 dvalid", dvalid, 1);
                chk("R6 wrap aout", aout, k % N);
                chk("R4 dout", dout, code_of(VMUL[v], VADD[v], k % N));
                @(negedge clk);
            end
        end

        // R9: code changes after store do not alter delivery
        load(11, 3);
        launch();
        load(2, 50);
        read_words(11, 3, 33);

        // R7 and R8: gradient mid-delivery
        @(negedge clk); grad_valid = 1'b1;
        load(9, 20);
        @(negedge clk); grad_valid = 1'b0;
        chk("R7 dvalid cleared", dvalid, 0);
        chk("R7 rw cleared", sweep_rd, 0);
        chk("R8 dout zero", dout, 0);
        chk("R8 aout zero", aout, 0);
        repeat (33) @(negedge clk);
        read_words(9, 20, 32);

        // R7: gradient mid-store with new codes
        load(4, 4);
        @(negedge clk); grad_valid = 1'b1;
        @(negedge clk); grad_valid = 1'b0;
        repeat (10) @(negedge clk);
        load(17, 33);
        launch();
        read_words(17, 33, 32);

        // R1: reset during delivery
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset dvalid", dvalid, 0);
        chk("R1 reset dout", dout, 0);
        chk("R1 reset aout", aout, 0);
        chk("R1 reset rw", sweep_rd, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R2 idle after reset", dvalid, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule